// File: doc/BRIEF.md
# Bus Fault Capture Controller

This block is the default target of a system bus. Every access that no other slave claims is routed to its fault port. The block completes that access with a single acknowledge pulse so the master can move on. It records the address of the offending access and raises an interrupt line that stays high until software clears it.

A second, register-style slave port gives the processor access to two locations. One holds the pending flag and is used to clear it. The other returns the captured fault address. When faults come one after another, the first address is kept until software clears the flag. A fault that arrives in the same cycle as the clear is never lost.

Top module: `bus_fault_capture`

## Requirements
- R1: While and after synchronous active-high reset, `irq`, `flt_ack` and `ctl_ack` are low.
- R2: A fault-port access, read or write, is acknowledged by `flt_ack` high in the cycle after `flt_cyc` and `flt_stb` are first seen high together.
- R3: `flt_ack` is a one-cycle pulse. It is not repeated while `flt_cyc` and `flt_stb` stay high; a new acknowledge needs the strobe or cycle to drop first.
- R4: `irq` rises in the same cycle as the fault acknowledge and stays high after the access ends, until software clears it.
- R5: The full 32-bit address of a fault taken while no fault is pending is latched and reads back at control offset 0x00C.
- R6: A fault arriving while `irq` is pending is still acknowledged, but the latched address is kept unchanged.
- R7: A control write to offset 0x000 with data bit 0 equal to 1 drops `irq` in the cycle of its acknowledge.
- R8: A control write to offset 0x000 with data bit 0 equal to 0 leaves `irq` unchanged.
- R9: A control read of offset 0x000 returns the pending flag in bit 0 and zero in bits 31:1.
- R10: `ctl_ack` rises in the cycle after `ctl_cyc` and `ctl_stb` are high and lasts one cycle; read data is valid while `ctl_ack` is high.
- R11: Reads of offsets other than 0x000 and 0x00C return zero. Writes to any offset other than 0x000, including 0x00C, change nothing.
- R12: When a clear write and a new fault are accepted in the same cycle, `irq` stays high and the new fault's address is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | output | 1 | Fault pending interrupt |
| ctl_adr | input | 12 | Control port byte offset |
| ctl_wdat | input | 32 | Control port write data |
| ctl_rdat | output | 32 | Control port read data |
| ctl_cyc | input | 1 | Control port cycle |
| ctl_stb | input | 1 | Control port strobe |
| ctl_we | input | 1 | Control port write enable |
| ctl_ack | output | 1 | Control port acknowledge |
| flt_adr | input | 32 | Fault port address |
| flt_wdat | input | 32 | Fault port write data (not stored) |
| flt_sel | input | 4 | Fault port byte select (not stored) |
| flt_cyc | input | 1 | Fault port cycle |
| flt_stb | input | 1 | Fault port strobe |
| flt_we | input | 1 | Fault port write enable (not stored) |
| flt_ack | output | 1 | Fault port acknowledge |

## Verification
A software clear of the pending flag and the arrival of a new fault can be accepted on the same clock edge. The bench sets up a pending fault first. It then drives a clear write on the control port and a fault access with a fresh address at the same falling edge, so that both are accepted on the next rising edge. The result is judged at the ports: both acknowledges must be high, `irq` must still be high, and a later read of offset 0x00C must return the fresh address and not the older one.

// File: rtl/bus_fault_pkg.sv
package bus_fault_pkg;
  localparam int unsigned FLT_ADDR_W = 32;
  localparam int unsigned FLT_DATA_W = 32;
  localparam int unsigned FLT_SEL_W  = 4;
  localparam int unsigned CTL_ADDR_W = 12;
  localparam int unsigned CTL_DATA_W = 32;

  // Control register offsets (byte addresses)
  localparam logic [CTL_ADDR_W-1:0] OFS_STATUS = 12'h000;
  localparam logic [CTL_ADDR_W-1:0] OFS_FADDR  = 12'h00C;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_FADDR  = 2'd1,
    REG_NONE   = 2'd2
  } ctl_reg_e;
endpackage

// File: rtl/fault_port.sv
module fault_port (
  input  logic clk,
  input  logic rst,
  input  logic cyc,
  input  logic stb,
  output logic ack,
  output logic take
);
  logic busy_q;
  logic ack_q;

  // A fault is taken once per strobe assertion
  assign take = cyc && stb && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= take;
      if (take)
        busy_q <= 1'b1;
      else if (!(cyc && stb))
        busy_q <= 1'b0;
    end
  end

  assign ack = ack_q;
endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_adr,
  input  logic              clear,
  output logic              pending,
  output logic [ADDR_W-1:0] addr
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              open_slot;

  // A clear in the same cycle frees the slot for the incoming fault
  assign open_slot = !pend_q || clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (take) begin
        pend_q <= 1'b1;
        if (open_slot)
          addr_q <= take_adr;
      end else if (clear) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pending = pend_q;
  assign addr    = addr_q;
endmodule

// File: rtl/ctl_port.sv
module ctl_port
  import bus_fault_pkg::*;
#(
  parameter int unsigned AW     = CTL_ADDR_W,
  parameter int unsigned DW     = CTL_DATA_W,
  parameter int unsigned FAW    = FLT_ADDR_W,
  parameter logic [AW-1:0] STATUS_OFS = OFS_STATUS,
  parameter logic [AW-1:0] FADDR_OFS  = OFS_FADDR
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  adr,
  input  logic [DW-1:0]  wdat,
  input  logic           cyc,
  input  logic           stb,
  input  logic           we,
  input  logic           pending,
  input  logic [FAW-1:0] fault_addr,
  output logic [DW-1:0]  rdat,
  output logic           ack,
  output logic           clear
);
  logic          ack_q;
  logic [DW-1:0] rdat_q;
  logic          accept;
  ctl_reg_e      sel;
  logic [DW-1:0] rd_val;

  assign accept = cyc && stb && !ack_q;

  always_comb begin
    if (adr == STATUS_OFS)
      sel = REG_STATUS;
    else if (adr == FADDR_OFS)
      sel = REG_FADDR;
    else
      sel = REG_NONE;
  end

  always_comb begin
    rd_val = '0;
    unique case (sel)
      REG_STATUS: rd_val[0] = pending;
      REG_FADDR:  rd_val[FAW-1:0] = fault_addr;
      default:    rd_val = '0;
    endcase
  end

  assign clear = accept && we && (sel == REG_STATUS) && wdat[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q  <= accept;
      rdat_q <= (accept && !we) ? rd_val : '0;
    end
  end

  assign ack  = ack_q;
  assign rdat = rdat_q;
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bus_fault_pkg::*;
#(
  parameter int unsigned FAW = FLT_ADDR_W,
  parameter int unsigned FDW = FLT_DATA_W,
  parameter int unsigned FSW = FLT_SEL_W,
  parameter int unsigned CAW = CTL_ADDR_W,
  parameter int unsigned CDW = CTL_DATA_W
) (
  input  logic           clk,
  input  logic           rst,
  output logic           irq,
  input  logic [CAW-1:0] ctl_adr,
  input  logic [CDW-1:0] ctl_wdat,
  output logic [CDW-1:0] ctl_rdat,
  input  logic           ctl_cyc,
  input  logic           ctl_stb,
  input  logic           ctl_we,
  output logic           ctl_ack,
  input  logic [FAW-1:0] flt_adr,
  input  logic [FDW-1:0] flt_wdat,
  input  logic [FSW-1:0] flt_sel,
  input  logic           flt_cyc,
  input  logic           flt_stb,
  input  logic           flt_we,
  output logic           flt_ack
);
  logic           take;
  logic           clr_req;
  logic           pend;
  logic [FAW-1:0] cap_addr;

  fault_port u_fport (
    .clk  (clk),
    .rst  (rst),
    .cyc  (flt_cyc),
    .stb  (flt_stb),
    .ack  (flt_ack),
    .take (take)
  );

  fault_latch #(.ADDR_W(FAW)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_adr (flt_adr),
    .clear    (clr_req),
    .pending  (pend),
    .addr     (cap_addr)
  );

  ctl_port #(.AW(CAW), .DW(CDW), .FAW(FAW)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .adr        (ctl_adr),
    .wdat       (ctl_wdat),
    .cyc        (ctl_cyc),
    .stb        (ctl_stb),
    .we         (ctl_we),
    .pending    (pend),
    .fault_addr (cap_addr),
    .rdat       (ctl_rdat),
    .ack        (ctl_ack),
    .clear      (clr_req)
  );

  assign irq = pend;
endmodule

// File: rtl/bus_fault_checker.sv
module bus_fault_checker #(
  parameter int unsigned FAW = 32,
  parameter int unsigned CAW = 12,
  parameter int unsigned CDW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           irq,
  input logic           flt_cyc,
  input logic           flt_stb,
  input logic           flt_ack,
  input logic           ctl_cyc,
  input logic           ctl_stb,
  input logic           ctl_we,
  input logic [CAW-1:0] ctl_adr,
  input logic [CDW-1:0] ctl_wdat,
  input logic           ctl_ack,
  input logic [FAW-1:0] cap_addr
);
  logic clr_seen;
  assign clr_seen = ctl_cyc && ctl_stb && ctl_we && !ctl_ack &&
                    (ctl_adr == '0) && ctl_wdat[0];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq && !flt_ack && !ctl_ack));

  assert_flt_ack_cause_R2: assert property (@(posedge clk) disable iff (rst)
    flt_ack |-> $past(flt_cyc && flt_stb));

  assert_flt_ack_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    flt_ack |=> !flt_ack);

  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> flt_ack);

  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_seen) |=> irq);

  assert_addr_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_seen) |=> $stable(cap_addr));

  assert_ctl_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_ack |-> ($past(ctl_cyc && ctl_stb) && !$past(ctl_ack)));
endmodule

bind bus_fault_capture bus_fault_checker #(.FAW(FAW), .CAW(CAW), .CDW(CDW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .flt_cyc  (flt_cyc),
  .flt_stb  (flt_stb),
  .flt_ack  (flt_ack),
  .ctl_cyc  (ctl_cyc),
  .ctl_stb  (ctl_stb),
  .ctl_we   (ctl_we),
  .ctl_adr  (ctl_adr),
  .ctl_wdat (ctl_wdat),
  .ctl_ack  (ctl_ack),
  .cap_addr (cap_addr)
);

// File: tb/bus_fault_capture_test.sv
module bus_fault_capture_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq;
  logic [11:0] ctl_adr  = '0;
  logic [31:0] ctl_wdat = '0;
  logic [31:0] ctl_rdat;
  logic        ctl_cyc = 1'b0, ctl_stb = 1'b0, ctl_we = 1'b0;
  logic        ctl_ack;
  logic [31:0] flt_adr  = '0;
  logic [31:0] flt_wdat = '0;
  logic [3:0]  flt_sel  = '0;
  logic        flt_cyc = 1'b0, flt_stb = 1'b0, flt_we = 1'b0;
  logic        flt_ack;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_fault_capture uut (
    .clk(clk), .rst(rst), .irq(irq),
    .ctl_adr(ctl_adr), .ctl_wdat(ctl_wdat), .ctl_rdat(ctl_rdat),
    .ctl_cyc(ctl_cyc), .ctl_stb(ctl_stb), .ctl_we(ctl_we), .ctl_ack(ctl_ack),
    .flt_adr(flt_adr), .flt_wdat(flt_wdat), .flt_sel(flt_sel),
    .flt_cyc(flt_cyc), .flt_stb(flt_stb), .flt_we(flt_we), .flt_ack(flt_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // fault access of one cycle; checks ack, irq and the quiet cycle after
  task automatic flt_access(input logic [31:0] a, input logic w, input logic exp_irq_before);
    check("R4 irq before fault", {31'b0, irq}, {31'b0, exp_irq_before});
    flt_adr = a; flt_we = w; flt_wdat = 32'hF000_000D; flt_sel = 4'hF;
    flt_cyc = 1'b1; flt_stb = 1'b1;
    tick();
    check("R2 fault ack", {31'b0, flt_ack}, 32'd1);
    check("R4 irq with ack", {31'b0, irq}, 32'd1);
    flt_cyc = 1'b0; flt_stb = 1'b0; flt_we = 1'b0;
    tick();
    check("R3 ack single", {31'b0, flt_ack}, 32'd0);
    check("R4 irq held", {31'b0, irq}, 32'd1);
  endtask

  task automatic ctl_read(input logic [11:0] a, output logic [31:0] d);
    ctl_adr = a; ctl_we = 1'b0; ctl_cyc = 1'b1; ctl_stb = 1'b1;
    tick();
    check("R10 read ack", {31'b0, ctl_ack}, 32'd1);
    d = ctl_rdat;
    ctl_cyc = 1'b0; ctl_stb = 1'b0;
    tick();
  endtask

  task automatic ctl_write(input logic [11:0] a, input logic [31:0] d);
    ctl_adr = a; ctl_wdat = d; ctl_we = 1'b1; ctl_cyc = 1'b1; ctl_stb = 1'b1;
    tick();
    check("R10 write ack", {31'b0, ctl_ack}, 32'd1);
    ctl_cyc = 1'b0; ctl_stb = 1'b0; ctl_we = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    repeat (3) tick();
    check("R1 irq in reset", {31'b0, irq}, 32'd0);
    check("R1 flt_ack in reset", {31'b0, flt_ack}, 32'd0);
    check("R1 ctl_ack in reset", {31'b0, ctl_ack}, 32'd0);
    rst = 1'b0;
    tick();
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_first_fault();
    logic [31:0] d;
    flt_access(32'hDEAD_BEEF, 1'b1, 1'b0);
    ctl_read(12'h00C, d);
    check("R5 captured address", d, 32'hDEAD_BEEF);
    ctl_read(12'h000, d);
    check("R9 status pending", d, 32'h0000_0001);
  endtask

  task automatic t_second_fault();
    logic [31:0] d;
    flt_access(32'h1234_5678, 1'b0, 1'b1);
    ctl_read(12'h00C, d);
    check("R6 address kept", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_zero();
    logic [31:0] d;
    ctl_write(12'h000, 32'hFFFF_FFFE);
    check("R8 irq unchanged", {31'b0, irq}, 32'd1);
    ctl_read(12'h000, d);
    check("R8 status still set", d, 32'h0000_0001);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    ctl_read(12'h010, d);
    check("R11 unmapped read zero", d, 32'd0);
    ctl_read(12'h004, d);
    check("R11 offset 4 read zero", d, 32'd0);
    ctl_write(12'h00C, 32'hFFFF_FFFF);
    ctl_read(12'h00C, d);
    check("R11 address read-only", d, 32'hDEAD_BEEF);
    ctl_write(12'h004, 32'h0000_0001);
    check("R11 write elsewhere no clear", {31'b0, irq}, 32'd1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    ctl_adr = 12'h000; ctl_wdat = 32'h1; ctl_we = 1'b1; ctl_cyc = 1'b1; ctl_stb = 1'b1;
    tick();
    check("R7 ack of clear", {31'b0, ctl_ack}, 32'd1);
    check("R7 irq dropped with ack", {31'b0, irq}, 32'd0);
    ctl_cyc = 1'b0; ctl_stb = 1'b0; ctl_we = 1'b0;
    tick();
    ctl_read(12'h000, d);
    check("R9 status clear", d, 32'd0);
  endtask

  task automatic t_held_strobe();
    logic [31:0] d;
    flt_adr = 32'hA5A5_0004; flt_cyc = 1'b1; flt_stb = 1'b1;
    tick();
    check("R2 ack held strobe", {31'b0, flt_ack}, 32'd1);
    tick();
    check("R3 no repeat 1", {31'b0, flt_ack}, 32'd0);
    tick();
    check("R3 no repeat 2", {31'b0, flt_ack}, 32'd0);
    flt_stb = 1'b0;
    tick();
    flt_adr = 32'h0000_0040; flt_stb = 1'b1;
    tick();
    check("R3 new strobe acked", {31'b0, flt_ack}, 32'd1);
    flt_cyc = 1'b0; flt_stb = 1'b0;
    tick();
    ctl_read(12'h00C, d);
    check("R5 capture after clear", d, 32'hA5A5_0004);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    flt_adr = 32'h0BAD_F00D; flt_cyc = 1'b1; flt_stb = 1'b1;
    ctl_adr = 12'h000; ctl_wdat = 32'h1; ctl_we = 1'b1; ctl_cyc = 1'b1; ctl_stb = 1'b1;
    tick();
    check("R12 fault ack", {31'b0, flt_ack}, 32'd1);
    check("R12 ctl ack", {31'b0, ctl_ack}, 32'd1);
    check("R12 irq kept", {31'b0, irq}, 32'd1);
    flt_cyc = 1'b0; flt_stb = 1'b0;
    ctl_cyc = 1'b0; ctl_stb = 1'b0; ctl_we = 1'b0;
    tick();
    ctl_read(12'h00C, d);
    check("R12 new address", d, 32'h0BAD_F00D);
  endtask

  task automatic t_ctl_pulse();
    ctl_adr = 12'h000; ctl_we = 1'b0; ctl_cyc = 1'b1; ctl_stb = 1'b1;
    check("R10 no ack before edge", {31'b0, ctl_ack}, 32'd0);
    tick();
    check("R10 ack", {31'b0, ctl_ack}, 32'd1);
    check("R9 read data", ctl_rdat, 32'd1);
    tick();
    check("R10 ack one cycle", {31'b0, ctl_ack}, 32'd0);
    ctl_cyc = 1'b0; ctl_stb = 1'b0;
    tick();
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_fault();
    t_second_fault();
    t_write_zero();
    t_unmapped();
    t_clear();
    t_held_strobe();
    t_same_cycle();
    t_ctl_pulse();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end
endmodule